// File: doc/BRIEF.md
# Speculative Load/Store Disambiguation Buffer

This block sits between several execution stages that run in program order around a ring and the data memory. Each stage issues loads and stores tagged with its stage number. A store does not go to memory. It is held in a small fully associative buffer, one value slot per stage for each address. A load takes the value from the closest store made by its own stage or by an older stage. If no such store is held, the load reads memory. Stage order is always counted from the current head stage.

Each entry records, for every stage, whether that stage loaded the address and whether it stored to it. A store can arrive after a younger stage has already loaded the same address. In that case the block reports the oldest such younger stage as a violation, and the surrounding control then squashes that stage and every stage after it. When the head stage commits, a two-state machine walks the entries one per cycle. It writes the head stage's stores to memory and clears that stage's bits. An entry with no bits left becomes free.

States: `ST_IDLE` accepts requests, squash and commit. `ST_DRAIN` scans entries and accepts no requests. Transitions: `ST_IDLE -> ST_DRAIN` on a commit pulse. `ST_DRAIN -> ST_IDLE` after the last entry has been scanned.

Top module: `arb_top`

## Requirements
- R1: After reset every entry is empty, `req_ready` is 1, and `busy`, `mem_we`, `viol_valid` and `ld_fwd` are 0.
- R2: A load to an address where no stage at or before the loading stage holds a store returns `mem_rd_data` for `mem_rd_addr = req_addr`, with `ld_fwd` 0, in the cycle it is accepted.
- R3: A load returns the value of the store from the nearest stage at or before its own stage, with `ld_fwd` 1. Position is `(stage - head_stage) mod NSTAGE`, and 0 is the oldest. Stores from younger stages are ignored.
- R4: A store never drives `mem_we` while it is held. `mem_we` is asserted only in `ST_DRAIN`.
- R5: An accepted store raises `viol_valid` in the same cycle if a stage younger than the storing stage has the load bit set for that address. `viol_stage` is the oldest such stage. Loads by older or equal stages cause no violation.
- R6: A `commit` pulse in `ST_IDLE` latches `head_stage` and holds `busy` for exactly NENTRY cycles. During that time there is one `mem_we` cycle per entry holding a store of that stage, in ascending entry order and with that stage's value. Afterwards the committed stage's bits are cleared.
- R7: A `squash` in `ST_IDLE` clears the load and store bits of `squash_stage` and of every younger stage in all entries. Later loads no longer see stores from the squashed stages.
- R8: An entry with no bits set is free. A request to a new address when no entry is free holds `req_ready` at 0. A request to an address already held is still accepted. Freeing entries by squash releases the stall.
- R9: While `busy` is 1, `req_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Load or store request present |
| req_store | input | 1 | 1 for store, 0 for load |
| req_stage | input | SW | Stage issuing the request |
| req_addr | input | AW | Data address |
| req_wdata | input | DW | Store value |
| req_ready | output | 1 | Request accepted this cycle |
| ld_data | output | DW | Load result, valid in the accept cycle |
| ld_fwd | output | 1 | Load result came from a buffered store |
| viol_valid | output | 1 | Accepted store hit a younger stage's load |
| viol_stage | output | SW | Oldest younger stage that loaded too early |
| mem_rd_addr | output | AW | Memory read address (combinational) |
| mem_rd_data | input | DW | Memory read data (combinational) |
| head_stage | input | SW | Oldest stage in the ring |
| commit | input | 1 | Commit pulse for the head stage |
| squash | input | 1 | Discard a stage and all younger stages |
| squash_stage | input | SW | First stage to discard |
| busy | output | 1 | Commit drain in progress |
| mem_we | output | 1 | Memory write enable |
| mem_waddr | output | AW | Memory write address |
| mem_wdata | output | DW | Memory write data |

## Verification
The checker assumes that NSTAGE is a power of two, so stage positions wrap within SW bits. It also assumes that `squash` and `commit` are never raised in the same cycle as an accepted request, and that `commit` is pulsed only while `busy` is low. The bench sends each request, squash and commit in a cycle of its own, with an idle cycle between them. It waits for `busy` to fall before the next action and changes `head_stage` only between commits.

// File: rtl/arb_pkg.sv
package arb_pkg;

    typedef enum logic [0:0] {
        ST_IDLE,
        ST_DRAIN
    } arb_state_e;

    // Age of a stage counted from the head: 0 is the oldest.
    function automatic int rel_pos(int stage, int head, int n);
        return (stage - head + n) % n;
    endfunction

endpackage

// File: rtl/arb_match.sv
module arb_match #(
    parameter int NENTRY = 8,
    parameter int AW     = 16,
    localparam int EW    = $clog2(NENTRY)
) (
    input  logic [NENTRY-1:0][AW-1:0] tags,
    input  logic [NENTRY-1:0]         live,
    input  logic [AW-1:0]             key,
    output logic                      hit,
    output logic [EW-1:0]             hit_idx,
    output logic                      free_ok,
    output logic [EW-1:0]             free_idx
);
    always_comb begin
        hit      = 1'b0;
        hit_idx  = '0;
        free_ok  = 1'b0;
        free_idx = '0;
        for (int i = NENTRY - 1; i >= 0; i--) begin
            if (live[i] && tags[i] == key) begin
                hit     = 1'b1;
                hit_idx = EW'(i);
            end
            if (!live[i]) begin
                free_ok  = 1'b1;
                free_idx = EW'(i);
            end
        end
    end
endmodule

// File: rtl/arb_fwd.sv
module arb_fwd
    import arb_pkg::*;
#(
    parameter int NSTAGE = 4,
    parameter int DW     = 16,
    localparam int SW    = $clog2(NSTAGE)
) (
    input  logic [NSTAGE-1:0]         st_bits,
    input  logic [NSTAGE-1:0][DW-1:0] vals,
    input  logic [SW-1:0]             head,
    input  logic [SW-1:0]             stage,
    output logic                      found,
    output logic [DW-1:0]             data
);
    always_comb begin
        int own;
        int s;
        own   = rel_pos(int'(stage), int'(head), NSTAGE);
        found = 1'b0;
        data  = '0;
        // Walk from oldest to the loader; a later hit is nearer.
        for (int r = 0; r < NSTAGE; r++) begin
            s = (int'(head) + r) % NSTAGE;
            if (r <= own && st_bits[s]) begin
                found = 1'b1;
                data  = vals[s];
            end
        end
    end
endmodule

// File: rtl/arb_viol.sv
module arb_viol
    import arb_pkg::*;
#(
    parameter int NSTAGE = 4,
    localparam int SW    = $clog2(NSTAGE)
) (
    input  logic [NSTAGE-1:0] ld_bits,
    input  logic [SW-1:0]     head,
    input  logic [SW-1:0]     stage,
    output logic              hit,
    output logic [SW-1:0]     victim
);
    always_comb begin
        int own;
        int s;
        own    = rel_pos(int'(stage), int'(head), NSTAGE);
        hit    = 1'b0;
        victim = '0;
        // Walk from youngest back; the last match is the oldest offender.
        for (int r = NSTAGE - 1; r >= 0; r--) begin
            s = (int'(head) + r) % NSTAGE;
            if (r > own && ld_bits[s]) begin
                hit    = 1'b1;
                victim = SW'(s);
            end
        end
    end
endmodule

// File: rtl/arb_top.sv
module arb_top
    import arb_pkg::*;
#(
    parameter int NSTAGE = 4,
    parameter int NENTRY = 8,
    parameter int AW     = 16,
    parameter int DW     = 16,
    localparam int SW    = $clog2(NSTAGE),
    localparam int EW    = $clog2(NENTRY)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_store,
    input  logic [SW-1:0] req_stage,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ready,
    output logic [DW-1:0] ld_data,
    output logic          ld_fwd,
    output logic          viol_valid,
    output logic [SW-1:0] viol_stage,
    output logic [AW-1:0] mem_rd_addr,
    input  logic [DW-1:0] mem_rd_data,
    input  logic [SW-1:0] head_stage,
    input  logic          commit,
    input  logic          squash,
    input  logic [SW-1:0] squash_stage,
    output logic          busy,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic [DW-1:0] mem_wdata
);
    logic [NENTRY-1:0][AW-1:0]             tag_q;
    logic [NENTRY-1:0][NSTAGE-1:0]         ld_q;
    logic [NENTRY-1:0][NSTAGE-1:0]         st_q;
    logic [NENTRY-1:0][NSTAGE-1:0][DW-1:0] val_q;

    arb_state_e    state_q, state_d;
    logic [EW-1:0] scan_q;
    logic [SW-1:0] cmt_q;

    logic [NENTRY-1:0]         live;
    logic                      hit, free_ok;
    logic [EW-1:0]             hit_idx, free_idx, sel_idx;
    logic [NSTAGE-1:0]         sel_st, sel_ld;
    logic [NSTAGE-1:0][DW-1:0] sel_vals;
    logic                      fwd_found, vio_hit;
    logic [DW-1:0]             fwd_data;
    logic [SW-1:0]             vio_stage;
    logic                      accept;

    always_comb begin
        for (int e = 0; e < NENTRY; e++) begin
            live[e] = (|ld_q[e]) | (|st_q[e]);
        end
    end

    arb_match #(.NENTRY(NENTRY), .AW(AW)) u_match (
        .tags(tag_q), .live(live), .key(req_addr),
        .hit(hit), .hit_idx(hit_idx), .free_ok(free_ok), .free_idx(free_idx)
    );

    assign sel_idx  = hit ? hit_idx : free_idx;
    assign sel_st   = hit ? st_q[hit_idx] : '0;
    assign sel_ld   = hit ? ld_q[hit_idx] : '0;
    assign sel_vals = val_q[hit_idx];

    arb_fwd #(.NSTAGE(NSTAGE), .DW(DW)) u_fwd (
        .st_bits(sel_st), .vals(sel_vals), .head(head_stage),
        .stage(req_stage), .found(fwd_found), .data(fwd_data)
    );

    arb_viol #(.NSTAGE(NSTAGE)) u_viol (
        .ld_bits(sel_ld), .head(head_stage), .stage(req_stage),
        .hit(vio_hit), .victim(vio_stage)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (commit) state_d = ST_DRAIN;
            ST_DRAIN: if (scan_q == EW'(NENTRY - 1)) state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            scan_q  <= '0;
            cmt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && commit) begin
                cmt_q  <= head_stage;
                scan_q <= '0;
            end else if (state_q == ST_DRAIN) begin
                scan_q <= scan_q + 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        busy        = (state_q == ST_DRAIN);
        req_ready   = (state_q == ST_IDLE) && (hit || free_ok);
        accept      = req_valid && req_ready;
        mem_rd_addr = req_addr;
        ld_data     = fwd_found ? fwd_data : mem_rd_data;
        ld_fwd      = accept && !req_store && fwd_found;
        viol_valid  = accept && req_store && vio_hit;
        viol_stage  = vio_stage;
        mem_we      = busy && st_q[scan_q][cmt_q];
        mem_waddr   = tag_q[scan_q];
        mem_wdata   = val_q[scan_q][cmt_q];
    end

    // Entry storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tag_q <= '0;
            ld_q  <= '0;
            st_q  <= '0;
            val_q <= '0;
        end else begin
            if (accept) begin
                tag_q[sel_idx] <= req_addr;
                if (req_store) begin
                    st_q[sel_idx][req_stage]  <= 1'b1;
                    val_q[sel_idx][req_stage] <= req_wdata;
                end else begin
                    ld_q[sel_idx][req_stage] <= 1'b1;
                end
            end
            if (state_q == ST_DRAIN) begin
                ld_q[scan_q][cmt_q] <= 1'b0;
                st_q[scan_q][cmt_q] <= 1'b0;
            end
            if (state_q == ST_IDLE && squash) begin
                for (int s = 0; s < NSTAGE; s++) begin
                    if (rel_pos(s, int'(head_stage), NSTAGE) >=
                        rel_pos(int'(squash_stage), int'(head_stage), NSTAGE)) begin
                        for (int e = 0; e < NENTRY; e++) begin
                            ld_q[e][s] <= 1'b0;
                            st_q[e][s] <= 1'b0;
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/arb_chk.sv
module arb_chk #(
    parameter int NSTAGE = 4,
    parameter int NENTRY = 8,
    localparam int SW    = $clog2(NSTAGE)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          mem_we,
    input logic          req_ready,
    input logic          req_valid,
    input logic          req_store,
    input logic [SW-1:0] req_stage,
    input logic [SW-1:0] head_stage,
    input logic          viol_valid,
    input logic [SW-1:0] viol_stage,
    input logic          ld_fwd,
    input logic          commit
);
    int            drain_cnt;
    logic [SW-1:0] pos_victim, pos_req;

    always_comb begin
        pos_victim = viol_stage - head_stage;
        pos_req    = req_stage - head_stage;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    drain_cnt <= 0;
        else if (busy) drain_cnt <= drain_cnt + 1;
        else           drain_cnt <= 0;
    end

    a_r4_write_only_in_drain: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_we);

    a_r9_stall_in_drain: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !req_ready);

    a_r6_commit_starts_drain: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !busy) |=> busy);

    a_r6_drain_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> drain_cnt == NENTRY);

    a_r5_victim_is_younger: assert property (@(posedge clk) disable iff (!rst_n)
        viol_valid |-> (req_valid && req_store && pos_victim > pos_req));

    a_r3_fwd_only_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        ld_fwd |-> (req_valid && req_ready && !req_store));
endmodule

bind arb_top arb_chk #(.NSTAGE(NSTAGE), .NENTRY(NENTRY)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .mem_we(mem_we),
    .req_ready(req_ready), .req_valid(req_valid), .req_store(req_store),
    .req_stage(req_stage), .head_stage(head_stage), .viol_valid(viol_valid),
    .viol_stage(viol_stage), .ld_fwd(ld_fwd), .commit(commit)
);

// File: tb/tb_arb_top.sv
module tb_arb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NSTAGE = 4;
    localparam int NENTRY = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_store = 1'b0;
    logic [1:0]  req_stage = '0;
    logic [15:0] req_addr = '0, req_wdata = '0;
    logic        req_ready, ld_fwd, viol_valid, busy, mem_we;
    logic [15:0] ld_data, mem_rd_addr, mem_rd_data, mem_waddr, mem_wdata;
    logic [1:0]  viol_stage;
    logic [1:0]  head_stage = '0, squash_stage = '0;
    logic        commit = 1'b0, squash = 1'b0;

    logic [15:0] mem_m [0:255];

    int checks = 0;
    int fails  = 0;

    typedef struct {
        bit          st;
        logic [15:0] d;
        bit          f;
        bit          v;
        logic [1:0]  vs;
        string       tag;
    } exp_t;

    typedef struct {
        logic [15:0] a;
        logic [15:0] d;
    } wr_t;

    exp_t sbq[$];
    wr_t  wrq[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    arb_top #(.NSTAGE(NSTAGE), .NENTRY(NENTRY), .AW(16), .DW(16)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
        .req_stage(req_stage), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .ld_data(ld_data), .ld_fwd(ld_fwd),
        .viol_valid(viol_valid), .viol_stage(viol_stage),
        .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .head_stage(head_stage), .commit(commit), .squash(squash),
        .squash_stage(squash_stage), .busy(busy), .mem_we(mem_we),
        .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
    );

    // Memory model
    assign mem_rd_data = mem_m[mem_rd_addr[7:0]];
    always @(posedge clk) if (mem_we) mem_m[mem_waddr[7:0]] <= mem_wdata;

    function automatic logic [15:0] init_val(logic [15:0] a);
        return 16'h1000 + a;
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Monitor: request results
    always @(negedge clk) begin
        if (rst_n && req_valid && req_ready) begin
            checks++;
            if (sbq.size() == 0) begin
                fails++;
                $display("FAIL R8 unexpected accept: actual addr %h expected none", req_addr);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                if (!e.st) begin
                    if (ld_data !== e.d || ld_fwd !== e.f || viol_valid !== 1'b0) begin
                        fails++;
                        $display("FAIL %s load: actual data %h fwd %b viol %b expected data %h fwd %b viol 0",
                                 e.tag, ld_data, ld_fwd, viol_valid, e.d, e.f);
                    end
                end else begin
                    if (viol_valid !== e.v || (e.v && viol_stage !== e.vs)) begin
                        fails++;
                        $display("FAIL %s store: actual viol %b stage %0d expected viol %b stage %0d",
                                 e.tag, viol_valid, viol_stage, e.v, e.vs);
                    end
                end
            end
        end
    end

    // Monitor: memory writes (any write without an expected entry breaks R4)
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            checks++;
            if (wrq.size() == 0) begin
                fails++;
                $display("FAIL R4 unexpected write: actual %h<=%h expected none", mem_waddr, mem_wdata);
            end else begin
                wr_t w;
                w = wrq.pop_front();
                if (mem_waddr !== w.a || mem_wdata !== w.d) begin
                    fails++;
                    $display("FAIL R6 write: actual %h<=%h expected %h<=%h",
                             mem_waddr, mem_wdata, w.a, w.d);
                end
            end
        end
    end

    task automatic drive(bit st, logic [1:0] stg, logic [15:0] a, logic [15:0] d);
        @(posedge clk); #1;
        req_valid = 1'b1; req_store = st; req_stage = stg; req_addr = a; req_wdata = d;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic ld(logic [1:0] stg, logic [15:0] a, logic [15:0] exp_d, bit exp_f, string tag);
        exp_t e;
        e.st = 1'b0; e.d = exp_d; e.f = exp_f; e.v = 1'b0; e.vs = '0; e.tag = tag;
        sbq.push_back(e);
        drive(1'b0, stg, a, '0);
    endtask

    task automatic st(logic [1:0] stg, logic [15:0] a, logic [15:0] d, bit exp_v,
                      logic [1:0] exp_vs, string tag);
        exp_t e;
        e.st = 1'b1; e.d = '0; e.f = 1'b0; e.v = exp_v; e.vs = exp_vs; e.tag = tag;
        sbq.push_back(e);
        drive(1'b1, stg, a, d);
    endtask

    task automatic do_squash(logic [1:0] stg);
        @(posedge clk); #1;
        squash = 1'b1; squash_stage = stg;
        @(posedge clk); #1;
        squash = 1'b0;
    endtask

    task automatic do_commit(logic [1:0] next_head);
        int n;
        @(posedge clk); #1;
        commit = 1'b1;
        @(posedge clk); #1;
        commit = 1'b0;
        @(negedge clk);
        chk("R9", "ready while draining", req_ready, 0);
        n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
        end
        chk("R6", "drain cycles", n, NENTRY);
        chk("R6", "pending writes left", wrq.size(), 0);
        head_stage = next_head;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem_m[i] = init_val(16'(i));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "req_ready", req_ready, 1);
        chk("R1", "busy", busy, 0);
        chk("R1", "mem_we", mem_we, 0);
        chk("R1", "viol_valid", viol_valid, 0);
        chk("R1", "ld_fwd", ld_fwd, 0);

        // R2: load with nothing buffered reads memory
        ld(2'd1, 16'h0010, init_val(16'h0010), 1'b0, "R2");

        // R3: nearest older-or-own store, head = 0
        st(2'd0, 16'h0020, 16'hAAAA, 1'b0, 2'd0, "R5");
        st(2'd2, 16'h0020, 16'hBBBB, 1'b0, 2'd0, "R5");
        ld(2'd1, 16'h0020, 16'hAAAA, 1'b1, "R3");
        ld(2'd3, 16'h0020, 16'hBBBB, 1'b1, "R3");
        ld(2'd2, 16'h0020, 16'hBBBB, 1'b1, "R3");

        // R5: older store after younger loads -> oldest offender is stage 1
        st(2'd0, 16'h0020, 16'hCCCC, 1'b1, 2'd1, "R5");
        // R5: only an older stage loaded 0x10 -> no violation
        st(2'd3, 16'h0010, 16'hDDDD, 1'b0, 2'd0, "R5");

        // R7: squash stage 1 and younger
        do_squash(2'd1);
        ld(2'd3, 16'h0020, 16'hCCCC, 1'b1, "R7");
        ld(2'd2, 16'h0010, init_val(16'h0010), 1'b0, "R7");

        // R6: commit stage 0 -> one write of 0xCCCC to 0x20
        begin
            wr_t w; w.a = 16'h0020; w.d = 16'hCCCC; wrq.push_back(w);
        end
        do_commit(2'd1);
        ld(2'd1, 16'h0020, 16'hCCCC, 1'b0, "R6");

        // R3/R5 with wrap, head = 1
        st(2'd0, 16'h0030, 16'h1111, 1'b0, 2'd0, "R5");
        ld(2'd3, 16'h0030, init_val(16'h0030), 1'b0, "R3");
        ld(2'd0, 16'h0030, 16'h1111, 1'b1, "R3");
        st(2'd1, 16'h0030, 16'h2222, 1'b1, 2'd3, "R5");
        do_squash(2'd3);

        // R8: fill, stall, hit while full, release
        do_squash(2'd1);
        for (int i = 0; i < NENTRY; i++) begin
            ld(2'd1, 16'h0040 + 16'(i), init_val(16'h0040 + 16'(i)), 1'b0, "R8");
        end
        @(posedge clk); #1;
        req_valid = 1'b1; req_store = 1'b0; req_stage = 2'd1; req_addr = 16'h0048;
        @(negedge clk);
        chk("R8", "ready when full", req_ready, 0);
        @(posedge clk); #1;
        req_valid = 1'b0;
        ld(2'd2, 16'h0043, init_val(16'h0043), 1'b0, "R8");
        do_squash(2'd1);
        ld(2'd1, 16'h0048, init_val(16'h0048), 1'b0, "R8");

        // R4/R6: two stores of the head stage drain in entry order
        st(2'd1, 16'h0050, 16'h5555, 1'b0, 2'd0, "R4");
        st(2'd1, 16'h0051, 16'h6666, 1'b0, 2'd0, "R4");
        st(2'd2, 16'h0050, 16'h7777, 1'b0, 2'd0, "R4");
        repeat (3) @(posedge clk);
        begin
            wr_t w;
            w.a = 16'h0050; w.d = 16'h5555; wrq.push_back(w);
            w.a = 16'h0051; w.d = 16'h6666; wrq.push_back(w);
        end
        do_commit(2'd2);
        ld(2'd2, 16'h0050, 16'h7777, 1'b1, "R6");
        ld(2'd3, 16'h0051, 16'h6666, 1'b0, "R6");

        repeat (2) @(negedge clk);
        chk("R3", "scoreboard drained", sbq.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule